// File: doc/BRIEF.md
# CEC Signal-Free-Time Gate

This block decides when a consumer-electronics-control transmitter may start driving the start bit of a new frame. It watches the bus level and counts how long the line has stayed high. Time is measured in half nominal bit periods: an external prescaler supplies a single-cycle tick every 1.2 ms, which is half of the 2.4 ms nominal bit. Counting halves makes the 0.5-period steps exact. The count is compared against a programmable idle threshold. When a transmit request is pending and the bus has been idle for long enough, the block issues a one-cycle grant.

A 3-bit setting chooses the threshold. The values 1 to 7 give fixed thresholds. The value 0 picks a default from the bus history:
- a short wait after this device's own attempt failed;
- a medium wait after another device's frame, which is also the state after reset;
- the longest wait after this device completed a transmission of its own.

A start-option bit chooses where the idle count restarts. It restarts either when the request is accepted, or at the end of every transmitted, received or failed message. The end-of-message flag presented together with the request marks a header-only, one-byte frame. That mark is echoed alongside the grant.

Top module: `sft_gate`

## Requirements
- R1: After reset the grant outputs are low, no request is pending, the idle count is zero and the default-mode history is "other device transmitted", so a setting of 0 then needs 9 half-bit ticks.
- R2: A setting n in 1..7 grants only after 2n-1 half-bit ticks of high bus, counted from the restart point (1 tick for n=1, 13 ticks for n=7).
- R3: With setting 0 the threshold is 5 ticks after `tx_fail`, 9 ticks after `rx_done` and 13 ticks after `tx_done`. When these events coincide, `tx_fail` wins over `tx_done`, and `tx_done` wins over `rx_done`.
- R4: When `start_on_end` is 0, the idle count restarts at the accepted request, so idle time before the request does not count.
- R5: When `start_on_end` is 1, the idle count restarts at each `tx_done`, `rx_done` or `tx_fail` pulse and keeps running without a request. A request made after enough idle time is granted on the second clock edge after it is taken.
- R6: Any cycle with `bus_high` low clears the idle count to zero. No grant is issued in the cycle after a low bus.
- R7: The grant is a single-cycle pulse and occurs only for a pending request. A request stays pending until granted. A `tx_start` that arrives while a request is pending is ignored, including its `tx_last` value, and does not restart the count.
- R8: `grant_single` is high together with `grant` exactly when `tx_last` was 1 in the cycle the request was accepted.
- R9: The idle count saturates at its maximum and never wraps. After 40 idle ticks, a setting-7 request in end-restart mode is still granted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse per half nominal bit period |
| bus_high | input | 1 | Synchronised bus level, 1 = idle/high |
| sft_setting | input | 3 | Idle-time setting; 0 = history default, n = 2n-1 half ticks |
| start_on_end | input | 1 | 0: count restarts at request; 1: count restarts at message end |
| tx_start | input | 1 | One-cycle transmit request |
| tx_last | input | 1 | End-of-message flag sampled with the request (one-byte frame) |
| tx_done | input | 1 | One-cycle pulse: own transmission completed |
| rx_done | input | 1 | One-cycle pulse: reception of another device's frame ended |
| tx_fail | input | 1 | One-cycle pulse: own transmission attempt failed |
| grant | output | 1 | One-cycle permission to begin the start bit |
| grant_single | output | 1 | High with `grant` when the granted frame is one byte |

## Verification
The assertions assume several things about the inputs:
- `half_tick`, `tx_start` and the three end events are single-cycle pulses.
- `bus_high` is already synchronous to `clk`.
- A setting change does not happen in the middle of a wait.

The stimulus keeps within these limits. Settings are written only while nothing is pending. Every tick is separated by idle cycles. End events and requests are never applied in the same cycle, so the restart point of the count is always unambiguous. Bus-low glitches are likewise applied as whole clock cycles, away from any tick.

// File: rtl/sft_pkg.sv
package sft_pkg;

    // Bus history used by the default (setting 0) threshold
    typedef enum logic [1:0] {
        HIST_OTHER = 2'd0,
        HIST_FAIL  = 2'd1,
        HIST_OWN   = 2'd2
    } hist_e;

    // Setting n asks for 0.5 + (n-1) bit periods = 2n-1 half periods
    function automatic int unsigned setting_halves(input int unsigned n);
        return 2 * n - 1;
    endfunction

endpackage

// File: rtl/sft_threshold.sv
module sft_threshold
    import sft_pkg::*;
#(
    parameter int CFG_W     = 3,
    parameter int CNT_W     = 4,
    parameter int DEF_FAIL  = 5,
    parameter int DEF_OTHER = 9,
    parameter int DEF_OWN   = 13
) (
    input  logic [CFG_W-1:0] setting,
    input  hist_e            hist,
    output logic [CNT_W-1:0] thr
);

    always_comb begin
        if (setting == '0) begin
            case (hist)
                HIST_FAIL: thr = CNT_W'(DEF_FAIL);
                HIST_OWN:  thr = CNT_W'(DEF_OWN);
                default:   thr = CNT_W'(DEF_OTHER);
            endcase
        end else begin
            thr = CNT_W'(setting_halves(32'(setting)));
        end
    end

endmodule

// File: rtl/sft_idle_counter.sv
module sft_idle_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             bus_high,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!bus_high || restart) begin
            s_d.cnt = '0;
        end else if (half_tick && s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // A low bus level always clears the idle count
    assert_low_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_high |=> cnt == '0);

    // A full count never wraps while the bus stays idle
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) && bus_high && !restart |=> cnt == CNT_MAX);

endmodule

// File: rtl/sft_gate.sv
module sft_gate
    import sft_pkg::*;
#(
    parameter int CFG_W     = 3,
    parameter int DEF_FAIL  = 5,
    parameter int DEF_OTHER = 9,
    parameter int DEF_OWN   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             bus_high,
    input  logic [CFG_W-1:0] sft_setting,
    input  logic             start_on_end,
    input  logic             tx_start,
    input  logic             tx_last,
    input  logic             tx_done,
    input  logic             rx_done,
    input  logic             tx_fail,
    output logic             grant,
    output logic             grant_single
);

    localparam int SET_MAX_HALVES = 2 * ((1 << CFG_W) - 1) - 1;
    localparam int MAX_A          = (SET_MAX_HALVES > DEF_OWN) ? SET_MAX_HALVES : DEF_OWN;
    localparam int MAX_HALVES     = (MAX_A > DEF_OTHER) ? MAX_A : DEF_OTHER;
    localparam int CNT_W          = $clog2(MAX_HALVES + 1);

    typedef struct packed {
        logic  pending;
        logic  single;
        logic  grant;
        hist_e hist;
    } gate_state_t;

    gate_state_t s_d, s_q;
    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] thr;
    logic             restart;
    logic             start_ok;
    logic             grant_now;

    sft_threshold #(
        .CFG_W    (CFG_W),
        .CNT_W    (CNT_W),
        .DEF_FAIL (DEF_FAIL),
        .DEF_OTHER(DEF_OTHER),
        .DEF_OWN  (DEF_OWN)
    ) u_thr (
        .setting(sft_setting),
        .hist   (s_q.hist),
        .thr    (thr)
    );

    sft_idle_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .bus_high (bus_high),
        .restart  (restart),
        .cnt      (idle_cnt)
    );

    always_comb begin
        s_d       = s_q;
        start_ok  = tx_start && !s_q.pending;
        grant_now = s_q.pending && bus_high && (idle_cnt >= thr);
        restart   = start_on_end ? (tx_done || rx_done || tx_fail) : start_ok;

        s_d.grant = grant_now;
        if (grant_now) s_d.pending = 1'b0;
        if (start_ok) begin
            s_d.pending = 1'b1;
            s_d.single  = tx_last;
        end

        if (tx_fail)      s_d.hist = HIST_FAIL;
        else if (tx_done) s_d.hist = HIST_OWN;
        else if (rx_done) s_d.hist = HIST_OTHER;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pending <= 1'b0;
            s_q.single  <= 1'b0;
            s_q.grant   <= 1'b0;
            s_q.hist    <= HIST_OTHER;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant        = s_q.grant;
    assign grant_single = s_q.grant && s_q.single;

    // Threshold always odd and within the supported half-tick range
    assert_thr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr >= 1) && (32'(thr) <= MAX_HALVES) && thr[0]);

    // Grant lasts exactly one cycle
    assert_grant_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    // No grant without a pending request
    assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pending |=> !grant);

    // A pending request is only retired by a grant
    assert_pending_until_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.pending) |-> grant);

    // No grant right after a low bus level
    assert_grant_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_high |=> !grant);

    // A failed attempt selects the shortest default wait
    assert_hist_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail |=> s_q.hist == HIST_FAIL);

    // Single-frame mark only ever accompanies a grant
    assert_single_with_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_single |-> grant);

endmodule

// File: tb/sft_gate_bench.sv
module sft_gate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       bus_high = 1'b1;
    logic [2:0] sft_setting = 3'd0;
    logic       start_on_end = 1'b0;
    logic       tx_start = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_done = 1'b0;
    logic       tx_fail = 1'b0;
    logic       grant;
    logic       grant_single;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;   // 50 MHz

    sft_gate u_sft_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_tick   (half_tick),
        .bus_high    (bus_high),
        .sft_setting (sft_setting),
        .start_on_end(start_on_end),
        .tx_start    (tx_start),
        .tx_last     (tx_last),
        .tx_done     (tx_done),
        .rx_done     (rx_done),
        .tx_fail     (tx_fail),
        .grant       (grant),
        .grant_single(grant_single)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fail);
            $finish;
        end
    end

    // event codes: 0 none, 1 tx_fail, 2 rx_done, 3 tx_done
    typedef struct packed {
        logic       opt;
        logic [2:0] cfg;
        logic [1:0] ev;
        logic       eom;
        logic [4:0] ticks;
        logic       ob;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 3'd1, 2'd0, 1'b0, 5'd1,  1'b0},
        '{1'b0, 3'd4, 2'd0, 1'b1, 5'd7,  1'b1},
        '{1'b0, 3'd7, 2'd0, 1'b0, 5'd13, 1'b0},
        '{1'b1, 3'd2, 2'd2, 1'b0, 5'd3,  1'b0},
        '{1'b1, 3'd5, 2'd3, 1'b1, 5'd9,  1'b1},
        '{1'b0, 3'd0, 2'd1, 1'b0, 5'd5,  1'b0},
        '{1'b0, 3'd0, 2'd2, 1'b0, 5'd9,  1'b0},
        '{1'b0, 3'd0, 2'd3, 1'b0, 5'd13, 1'b0},
        '{1'b1, 3'd0, 2'd1, 1'b1, 5'd5,  1'b1},
        '{1'b1, 3'd0, 2'd3, 1'b0, 5'd13, 1'b0},
        '{1'b0, 3'd0, 2'd0, 1'b0, 5'd9,  1'b0},
        '{1'b1, 3'd6, 2'd1, 1'b0, 5'd11, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        half_tick = 0; bus_high = 1; tx_start = 0; tx_last = 0;
        tx_done = 0; rx_done = 0; tx_fail = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire_event(input int ev);
        if (ev != 0) begin
            @(negedge clk);
            tx_fail = (ev == 1);
            rx_done = (ev == 2);
            tx_done = (ev == 3);
            @(negedge clk);
            tx_fail = 0; rx_done = 0; tx_done = 0;
        end
    endtask

    task automatic request(input logic eom);
        @(negedge clk);
        tx_start = 1'b1; tx_last = eom;
        @(negedge clk);
        tx_start = 1'b0; tx_last = 1'b0;
    endtask

    task automatic pre_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) half_tick = 1'b1;
            @(negedge clk) half_tick = 1'b0;
        end
    endtask

    // Pulse ticks, noting the first tick after which grant appears
    task automatic measure(input int maxt, output int got, output int ngr, output int ob);
        got = -1; ngr = 0; ob = 0;
        for (int t = 1; t <= maxt; t++) begin
            @(negedge clk) half_tick = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                half_tick = 1'b0;
                if (grant) begin
                    ngr++;
                    if (got < 0) got = t;
                    if (grant_single) ob = 1;
                end
            end
        end
    endtask

    // Watch for a grant over a few cycles without ticks
    task automatic watch(input int n, output int ngr);
        ngr = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (grant) ngr++;
        end
    endtask

    initial begin
        int got, ngr, ob;

        // ---- vector table: R2 / R3 / R7 / R8 ----
        for (int i = 0; i < 12; i++) begin
            do_reset();
            start_on_end = VEC[i].opt;
            sft_setting  = VEC[i].cfg;
            fire_event(int'(VEC[i].ev));
            request(VEC[i].eom);
            measure(16, got, ngr, ob);
            check((VEC[i].cfg == 0) ? "R3 default wait ticks" : "R2 setting wait ticks",
                  got, int'(VEC[i].ticks));
            check("R7 one grant pulse", ngr, 1);
            check("R8 single-frame mark", ob, int'(VEC[i].ob));
        end

        // ---- R1: reset state and default history ----
        do_reset();
        start_on_end = 0; sft_setting = 0;
        @(negedge clk);
        check("R1 grant low after reset", int'(grant), 0);
        check("R1 grant_single low after reset", int'(grant_single), 0);
        measure(4, got, ngr, ob);
        check("R1 no grant without request", ngr, 0);
        request(1'b0);
        measure(16, got, ngr, ob);
        check("R1 reset history default 9", got, 9);

        // ---- R4: idle time before request not counted ----
        do_reset();
        start_on_end = 0; sft_setting = 3'd3;
        pre_ticks(10);
        request(1'b0);
        measure(16, got, ngr, ob);
        check("R4 count restarts at request", got, 5);

        // ---- R5: count restarts at message end, runs without request ----
        do_reset();
        start_on_end = 1; sft_setting = 3'd3;
        fire_event(2);
        pre_ticks(10);
        request(1'b0);
        watch(3, ngr);
        check("R5 prompt grant after long idle", ngr, 1);
        do_reset();
        start_on_end = 1; sft_setting = 3'd3;
        fire_event(2);
        pre_ticks(3);
        fire_event(1);
        request(1'b0);
        measure(16, got, ngr, ob);
        check("R5 second end event restarts count", got, 5);

        // ---- R6: low bus clears the count ----
        do_reset();
        start_on_end = 0; sft_setting = 3'd3;
        request(1'b0);
        measure(3, got, ngr, ob);
        check("R6 no grant before threshold", ngr, 0);
        @(negedge clk) bus_high = 1'b0;
        @(negedge clk) bus_high = 1'b1;
        measure(16, got, ngr, ob);
        check("R6 count restarts after low bus", got, 5);

        // ---- R7: second request while pending is ignored ----
        do_reset();
        start_on_end = 0; sft_setting = 3'd2;
        request(1'b0);
        measure(2, got, ngr, ob);
        check("R7 still pending", ngr, 0);
        request(1'b1);
        measure(16, got, ngr, ob);
        check("R7 ignored request keeps count", got, 1);
        check("R7 ignored request keeps flag (R8)", ob, 0);

        // ---- R9: saturation ----
        do_reset();
        start_on_end = 1; sft_setting = 3'd7;
        fire_event(2);
        pre_ticks(40);
        request(1'b0);
        watch(3, ngr);
        check("R9 saturated count still grants", ngr, 1);

        // ---- R3: priority of coinciding events ----
        do_reset();
        start_on_end = 0; sft_setting = 0;
        @(negedge clk); tx_fail = 1; tx_done = 1;
        @(negedge clk); tx_fail = 0; tx_done = 0;
        request(1'b0);
        measure(16, got, ngr, ob);
        check("R3 fail beats own done", got, 5);
        do_reset();
        start_on_end = 0; sft_setting = 0;
        @(negedge clk); rx_done = 1; tx_done = 1;
        @(negedge clk); rx_done = 0; tx_done = 0;
        request(1'b0);
        measure(16, got, ngr, ob);
        check("R3 own done beats rx done", got, 13);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule